// File: doc/BRIEF.md
# Half-Duplex Debug Data Transfer Channel

This block is a 64-bit mailbox that links a processor core with an external debugger. It holds two 32-bit slots. The receive slot carries data from the debugger to the core. The transmit slot carries data from the core to the debugger. Each slot has its own full flag.

The core reaches both slots through one 64-bit register port, so a single access moves both halves. On a core write, the upper word goes to the receive slot and the lower word goes to the transmit slot, but only the transmit flag is raised. On a core read, the transmit slot appears in the upper word and the receive slot in the lower word. A core read is qualified and cleared by the receive flag alone.

The debugger has its own 32-bit path in each direction and can see both flags. When a core access and a debugger access touch the same slot in the same cycle, the core wins. The reset is asynchronous and active low.

Top module: `dtc_channel`

## Requirements
- R1: While `rst_ni` is low, both flags are 0 and both slots are zero. After release, `dbg_rdata_o` reads 0.
- R2: A core write stores `core_wdata_i[63:32]` in the receive slot and leaves the receive flag at its prior value.
- R3: A core write stores `core_wdata_i[31:0]` in the transmit slot. From the next cycle on, the transmit flag is 1.
- R4: A core read while the receive flag is 1 returns, in the same cycle, the transmit slot on bits 63:32 and the receive slot on bits 31:0.
- R5: A core read while the receive flag is 0 returns all zeros.
- R6: Every core read clears the receive flag from the next cycle on, whether its data was valid or not.
- R7: A debugger write with no core access in the same cycle stores `dbg_wdata_i` in the receive slot and sets the receive flag.
- R8: `dbg_rdata_o` always shows the transmit slot. A debugger read with no core write in the same cycle clears the transmit flag.
- R9: A debugger write in the same cycle as a core read is dropped, and the receive flag ends at 0.
- R10: A debugger write in the same cycle as a core write is dropped. The receive slot takes the core's upper word, and the receive flag is unchanged.
- R11: A debugger read in the same cycle as a core write returns the old transmit data. The transmit slot takes the new lower word, and the transmit flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_wr_i | input | 1 | Core register write strobe |
| core_wdata_i | input | 64 | Core write data (upper word to receive slot, lower word to transmit slot) |
| core_rd_i | input | 1 | Core register read strobe |
| core_rdata_o | output | 64 | Core read data, zero when the receive flag is clear |
| dbg_wr_i | input | 1 | Debugger write strobe into the receive slot |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rd_i | input | 1 | Debugger read strobe of the transmit slot |
| dbg_rdata_o | output | 32 | Transmit slot contents |
| dbg_rx_full_o | output | 1 | Receive flag |
| dbg_tx_full_o | output | 1 | Transmit flag |

## Verification
Two collisions can land in one cycle.

- **Receive flag:** a core read, which clears it, can meet a debugger write, which sets it.
- **Transmit flag:** a core write, which sets it, can meet a debugger read, which clears it.

The bench provokes each collision by raising both strobes in the same cycle. It judges the result from the flag outputs in the following cycle. A later core read shows which word the receive slot kept. For the transmit side, the debugger read data in the collision cycle shows whether the old word was still delivered.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  parameter int unsigned WORD_W = 32;

  // Flag update request: en selects an update, val is the new flag value
  typedef struct packed {
    logic en;
    logic val;
  } flag_op_t;
endpackage

// File: rtl/dtc_slot.sv
module dtc_slot #(
  parameter int unsigned W = dtc_pkg::WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pri_ld_i,
  input  logic [W-1:0]        pri_data_i,
  input  logic                sec_ld_i,
  input  logic [W-1:0]        sec_data_i,
  input  dtc_pkg::flag_op_t   pri_flag_i,
  input  dtc_pkg::flag_op_t   sec_flag_i,
  output logic [W-1:0]        data_o,
  output logic                full_o
);
  logic [W-1:0] data_q;
  logic         full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (pri_ld_i) begin
      data_q <= pri_data_i;
    end else if (sec_ld_i) begin
      data_q <= sec_data_i;
    end
  end

  // Primary requester (core side) wins the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else if (pri_flag_i.en) begin
      full_q <= pri_flag_i.val;
    end else if (sec_flag_i.en) begin
      full_q <= sec_flag_i.val;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/dtc_core_rd.sv
module dtc_core_rd #(
  parameter int unsigned W = dtc_pkg::WORD_W,
  localparam int unsigned REG_W = 2 * W
) (
  input  logic [W-1:0]     tx_data_i,
  input  logic [W-1:0]     rx_data_i,
  input  logic             rx_full_i,
  output logic [REG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rx_full_i) begin
      rdata_o = {tx_data_i, rx_data_i};
    end
  end
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel #(
  parameter int unsigned WORD_W = dtc_pkg::WORD_W,
  localparam int unsigned REG_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_wr_i,
  input  logic [REG_W-1:0]  core_wdata_i,
  input  logic              core_rd_i,
  output logic [REG_W-1:0]  core_rdata_o,
  input  logic              dbg_wr_i,
  input  logic [WORD_W-1:0] dbg_wdata_i,
  input  logic              dbg_rd_i,
  output logic [WORD_W-1:0] dbg_rdata_o,
  output logic              dbg_rx_full_o,
  output logic              dbg_tx_full_o
);
  import dtc_pkg::*;

  logic [WORD_W-1:0] rx_data, tx_data;
  logic              rx_full, tx_full;
  logic              dbg_wr_eff;
  flag_op_t          rx_pri_op, rx_sec_op, tx_pri_op, tx_sec_op;

  // Any core access to the register drops a colliding debugger write
  assign dbg_wr_eff = dbg_wr_i & ~core_wr_i & ~core_rd_i;

  assign rx_pri_op = '{en: core_rd_i,  val: 1'b0};
  assign rx_sec_op = '{en: dbg_wr_eff, val: 1'b1};
  assign tx_pri_op = '{en: core_wr_i,  val: 1'b1};
  assign tx_sec_op = '{en: dbg_rd_i,   val: 1'b0};

  dtc_slot #(.W(WORD_W)) u_rx_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pri_ld_i   (core_wr_i),
    .pri_data_i (core_wdata_i[REG_W-1:WORD_W]),
    .sec_ld_i   (dbg_wr_eff),
    .sec_data_i (dbg_wdata_i),
    .pri_flag_i (rx_pri_op),
    .sec_flag_i (rx_sec_op),
    .data_o     (rx_data),
    .full_o     (rx_full)
  );

  dtc_slot #(.W(WORD_W)) u_tx_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pri_ld_i   (core_wr_i),
    .pri_data_i (core_wdata_i[WORD_W-1:0]),
    .sec_ld_i   (1'b0),
    .sec_data_i ('0),
    .pri_flag_i (tx_pri_op),
    .sec_flag_i (tx_sec_op),
    .data_o     (tx_data),
    .full_o     (tx_full)
  );

  dtc_core_rd #(.W(WORD_W)) u_core_rd (
    .tx_data_i (tx_data),
    .rx_data_i (rx_data),
    .rx_full_i (rx_full),
    .rdata_o   (core_rdata_o)
  );

  assign dbg_rdata_o   = tx_data;
  assign dbg_rx_full_o = rx_full;
  assign dbg_tx_full_o = tx_full;
endmodule

// File: rtl/dtc_channel_chk.sv
module dtc_channel_chk #(
  parameter int unsigned WORD_W = dtc_pkg::WORD_W,
  localparam int unsigned REG_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_wr_i,
  input logic              core_rd_i,
  input logic [REG_W-1:0]  core_rdata_o,
  input logic              dbg_wr_i,
  input logic              dbg_rd_i,
  input logic [WORD_W-1:0] dbg_rdata_o,
  input logic              dbg_rx_full_o,
  input logic              dbg_tx_full_o
);
  AST_CORE_WR_SETS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i |=> dbg_tx_full_o); // R3
  AST_CORE_WR_KEEPS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i && !core_rd_i |=> dbg_rx_full_o == $past(dbg_rx_full_o)); // R2
  AST_GATHER_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_i && dbg_rx_full_o |-> core_rdata_o[REG_W-1:WORD_W] == dbg_rdata_o); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_i && !dbg_rx_full_o |-> core_rdata_o == '0); // R5
  AST_CORE_RD_CLEARS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_i |=> !dbg_rx_full_o); // R6
  AST_DBG_WR_SETS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr_i && !core_rd_i && !core_wr_i |=> dbg_rx_full_o); // R7
  AST_DBG_RD_CLEARS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rd_i && !core_wr_i |=> !dbg_tx_full_o); // R8
  AST_DBG_RD_SAMPLES_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(core_wr_i) |-> $stable(dbg_rdata_o)); // R11
endmodule

bind dtc_channel dtc_channel_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_wr_i     (core_wr_i),
  .core_rd_i     (core_rd_i),
  .core_rdata_o  (core_rdata_o),
  .dbg_wr_i      (dbg_wr_i),
  .dbg_rd_i      (dbg_rd_i),
  .dbg_rdata_o   (dbg_rdata_o),
  .dbg_rx_full_o (dbg_rx_full_o),
  .dbg_tx_full_o (dbg_tx_full_o)
);

// File: tb/sim_dtc_channel.sv
module sim_dtc_channel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        core_wr = 1'b0, core_rd = 1'b0, dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [63:0] core_wdata = '0;
  logic [31:0] dbg_wdata = '0;
  logic [63:0] core_rdata;
  logic [31:0] dbg_rdata;
  logic        rx_full, tx_full;
  int          checks = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dtc_channel u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .core_wr_i     (core_wr),
    .core_wdata_i  (core_wdata),
    .core_rd_i     (core_rd),
    .core_rdata_o  (core_rdata),
    .dbg_wr_i      (dbg_wr),
    .dbg_wdata_i   (dbg_wdata),
    .dbg_rd_i      (dbg_rd),
    .dbg_rdata_o   (dbg_rdata),
    .dbg_rx_full_o (rx_full),
    .dbg_tx_full_o (tx_full)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One access cycle. Same-cycle outputs are sampled before the edge, and
  // the strobes are dropped at the next falling edge.
  task automatic access(input logic cw, input logic [63:0] cwd, input logic cr,
                        input logic dw, input logic [31:0] dwd, input logic dr,
                        output logic [63:0] crd, output logic [31:0] drd);
    @(negedge clk);
    core_wr = cw; core_wdata = cwd; core_rd = cr;
    dbg_wr = dw; dbg_wdata = dwd; dbg_rd = dr;
    #1;
    crd = core_rdata;
    drd = dbg_rdata;
    @(negedge clk);
    core_wr = 0; core_rd = 0; dbg_wr = 0; dbg_rd = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 rx_full in reset", 64'(rx_full), 64'd0);
    chk("R1 tx_full in reset", 64'(tx_full), 64'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 tx slot zero", 64'(dbg_rdata), 64'd0);
    chk("R1 rx_full after release", 64'(rx_full), 64'd0);
  endtask

  task automatic t_core_write();
    logic [63:0] c; logic [31:0] d;
    access(1, 64'hA1B2C3D4_11223344, 0, 0, '0, 0, c, d);
    chk("R3 tx_full set", 64'(tx_full), 64'd1);
    chk("R3 tx slot low word", 64'(dbg_rdata), 64'h11223344);
    chk("R2 rx_full unchanged at 0", 64'(rx_full), 64'd0);
    access(0, '0, 1, 0, '0, 0, c, d);
    chk("R5 empty read zero", c, 64'd0);
    chk("R6 rx_full stays 0", 64'(rx_full), 64'd0);
  endtask

  task automatic t_dbg_write_core_read();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 1, 32'hCAFE0001, 0, c, d);
    chk("R7 rx_full set", 64'(rx_full), 64'd1);
    access(0, '0, 1, 0, '0, 0, c, d);
    chk("R4 gather order", c, 64'h11223344_CAFE0001);
    chk("R6 rx_full cleared", 64'(rx_full), 64'd0);
    chk("R6 tx_full untouched", 64'(tx_full), 64'd1);
  endtask

  task automatic t_core_write_full_rx();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 1, 32'hDEAD0002, 0, c, d);
    access(1, 64'h55667788_99AABBCC, 0, 0, '0, 0, c, d);
    chk("R2 rx_full stays 1", 64'(rx_full), 64'd1);
    access(0, '0, 1, 0, '0, 0, c, d);
    chk("R2 R4 rx high word gathered", c, 64'h99AABBCC_55667788);
  endtask

  task automatic t_dbg_read();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 0, '0, 1, c, d);
    chk("R8 dbg read data", 64'(d), 64'h99AABBCC);
    chk("R8 tx_full cleared", 64'(tx_full), 64'd0);
  endtask

  task automatic t_race_rd_vs_dbg_wr();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 1, 1, 32'h00000077, 0, c, d);
    chk("R9 read while empty zero", c, 64'd0);
    chk("R9 rx_full stays 0", 64'(rx_full), 64'd0);
    access(0, '0, 0, 1, 32'h00000010, 0, c, d);
    access(0, '0, 1, 1, 32'h00000020, 0, c, d);
    chk("R9 read returns prior rx", c, 64'h99AABBCC_00000010);
    chk("R9 rx_full cleared over dbg write", 64'(rx_full), 64'd0);
  endtask

  task automatic t_race_wr_vs_dbg_wr();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 1, 32'h00000030, 0, c, d);
    access(1, 64'hABCD0000_0000EEEE, 0, 1, 32'h00000040, 0, c, d);
    chk("R10 rx_full unchanged", 64'(rx_full), 64'd1);
    access(0, '0, 1, 0, '0, 0, c, d);
    chk("R10 core high word kept", c, 64'h0000EEEE_ABCD0000);
  endtask

  task automatic t_race_wr_vs_dbg_rd();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 0, '0, 1, c, d);
    chk("R8 tx_full cleared", 64'(tx_full), 64'd0);
    access(1, 64'h0BADF00D_12345678, 0, 0, '0, 1, c, d);
    chk("R11 old tx data read", 64'(d), 64'h0000EEEE);
    chk("R11 tx_full ends 1", 64'(tx_full), 64'd1);
    chk("R11 new tx data", 64'(dbg_rdata), 64'h12345678);
  endtask

  task automatic t_reset_mid();
    logic [63:0] c; logic [31:0] d;
    access(0, '0, 0, 1, 32'h0F0F0F0F, 0, c, d);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async rx_full clear", 64'(rx_full), 64'd0);
    chk("R1 async tx_full clear", 64'(tx_full), 64'd0);
    chk("R1 async tx slot clear", 64'(dbg_rdata), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_core_write();
    t_dbg_write_core_read();
    t_core_write_full_rx();
    t_dbg_read();
    t_race_rd_vs_dbg_wr();
    t_race_wr_vs_dbg_wr();
    t_race_wr_vs_dbg_rd();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule